// File: doc/BRIEF.md
# Multi-mode PIO cycle timer

This block drives the host-side control strobes for one programmed-I/O transfer on a parallel disk interface. A single-clock start pulse launches a cycle. At that moment the block captures the timing mode, the transfer direction and the write data word. One cycle counter then runs from zero. Every edge of the cycle is a compare of that counter against three values that depend on the mode: where the strobe rises, where it falls, and the last count of the cycle.

The device can slow the host down with its ready line. If ready is low when the counter reaches the strobe-fall count, the counter freezes and the strobe stays active. The stretch is bounded at 1250 ns, which is 125 clocks at the default 10 ns clock. When the bound is reached, the cycle finishes anyway and a timeout flag is raised. A done pulse marks the last count of every cycle. A new start presented in that done cycle chains straight into the next transfer.

Top module: `pio_cycle_timer`

## Requirements
- R1: While reset is asserted, and once it is released with no start seen, all strobes, the bus output enable, the bus data, done and timeout are 0.
- R2: A start pulse seen while idle is accepted at that clock edge, and the counter holds 0 in the following cycle.
- R3: With write_i=1 captured, only wr_strobe_o is driven; with write_i=0 captured, only rd_strobe_o is driven. The two strobes are never high together.
- R4: The strobe is high while the count lies in [on, off], and done is high at count last. The values (on, off, last) are (7,36,67) for mode 0, (5,34,45) for mode 1, (3,33,37) for mode 2, (3,11,22) for mode 3 and (3,10,16) for mode 4. Mode codes 5 to 7 use the mode 4 values.
- R5: bus_oe_o is high in every cycle of a write transfer and low otherwise. bus_data_o carries the captured word while bus_oe_o is high and 0 otherwise.
- R6: A start pulse that arrives during a cycle, other than in its done cycle, is ignored, and the block returns to idle after done.
- R7: If iordy_i is low at a clock edge where the count equals off, the counter does not advance and the strobe stays high. Each such edge adds one cycle to the strobe and to the transfer.
- R8: At most 125 clocks of stretch are allowed (MAX_WAIT_NS/CLK_PERIOD_NS). At the 126th edge that sees ready low at off, the counter advances and timeout_o rises. timeout_o stays high until the next accepted start clears it. Exactly 125 low edges does not set it.
- R9: Changes on mode_i, write_i and wdata_i after a start has been accepted have no effect on that transfer.
- R10: done_o is a one-clock pulse. A start presented in the done cycle is accepted there, and the new count 0 follows with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse for one transfer |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| mode_i | input | 3 | Timing mode code, 0 to 4 (5 to 7 act as 4) |
| iordy_i | input | 1 | Device ready; low stretches the cycle |
| wdata_i | input | DATA_W | Word to place on the bus for a write |
| rd_strobe_o | output | 1 | Read strobe, active high |
| wr_strobe_o | output | 1 | Write strobe, active high |
| bus_oe_o | output | 1 | Data bus output enable |
| bus_data_o | output | DATA_W | Data driven to the bus |
| done_o | output | 1 | One-clock pulse on the last count |
| timeout_o | output | 1 | Ready stretch reached its limit in the latest transfer |

## Verification
The hardest situation to reach is the stall-limit boundary. The bench must keep the ready line low at the strobe-fall count for exactly 125 edges, which must not time out, and for 126 or more edges, which must. To get there, the stimulus drives ready low from the moment of acceptance. It counts observed cycles from count 0 and raises ready at off plus the requested stall, which lands each case on the exact edge. The same vectors change the mode, direction and data inputs and pulse start in the middle of the cycle, to show that the captured transfer runs unchanged.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int CNT_W  = 7;
  localparam int MODE_W = 3;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [MODE_W-1:0] mode_t;

  // Edge positions of one transfer, all in counter units.
  typedef struct packed {
    cnt_t on_at;    // strobe becomes active
    cnt_t off_at;   // strobe released (stall point)
    cnt_t last_at;  // final count, done pulse
  } edge_set_t;

  // Per-mode timing table; codes above the fastest mode reuse it.
  function automatic edge_set_t lookup_edges(input mode_t m);
    edge_set_t e;
    case (m)
      3'd0:    e = '{on_at: 7'd7, off_at: 7'd36, last_at: 7'd67};
      3'd1:    e = '{on_at: 7'd5, off_at: 7'd34, last_at: 7'd45};
      3'd2:    e = '{on_at: 7'd3, off_at: 7'd33, last_at: 7'd37};
      3'd3:    e = '{on_at: 7'd3, off_at: 7'd11, last_at: 7'd22};
      default: e = '{on_at: 7'd3, off_at: 7'd10, last_at: 7'd16};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/pio_req_capture.sv
module pio_req_capture
  import pio_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  logic              last,
  input  mode_t             mode_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_t             mode_q,
  output logic              write_q,
  output logic [DATA_W-1:0] data_q
);

  mode_t             mode_d;
  logic              write_d;
  logic [DATA_W-1:0] data_d;

  // Next-state: capture only on an accepted start.
  always_comb begin
    mode_d  = mode_q;
    write_d = write_q;
    data_d  = data_q;
    if (accept) begin
      mode_d  = mode_i;
      write_d = write_i;
      data_d  = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      write_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      mode_q  <= mode_d;
      write_q <= write_d;
      data_q  <= data_d;
    end
  end

  // R9: captured transfer settings stay fixed while a cycle runs
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(mode_q) && $stable(write_q) && $stable(data_q)));

endmodule

// File: rtl/pio_stall_guard.sv
module pio_stall_guard
  import pio_timer_pkg::*;
#(
  parameter int STALL_LIMIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic busy,
  input  cnt_t cnt,
  input  cnt_t off_at,
  input  logic iordy_i,
  output logic hold,
  output logic timeout_q
);

  localparam int STALL_W = $clog2(STALL_LIMIT + 1);

  logic [STALL_W-1:0] stall_q, stall_d;
  logic               timeout_d;
  logic               at_off;
  logic               limit_hit;
  logic               expire;

  assign at_off    = busy && (cnt == off_at);
  assign limit_hit = (stall_q == STALL_W'(STALL_LIMIT));
  assign hold      = at_off && !iordy_i && !limit_hit;
  assign expire    = at_off && !iordy_i && limit_hit;

  always_comb begin
    stall_d   = stall_q;
    timeout_d = timeout_q;
    if (accept) begin
      stall_d   = '0;
      timeout_d = 1'b0;
    end else begin
      if (hold) begin
        stall_d = stall_q + STALL_W'(1);
      end
      if (expire) begin
        timeout_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q   <= '0;
      timeout_q <= 1'b0;
    end else begin
      stall_q   <= stall_d;
      timeout_q <= timeout_d;
    end
  end

  // R8: hitting the stall bound raises the timeout flag
  a_r8_timeout_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> timeout_q);

  // R8: an accepted start clears the timeout flag
  a_r8_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !timeout_q);

  // R8: the stall count never passes the bound
  a_r8_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (stall_q <= STALL_W'(STALL_LIMIT)));

endmodule

// File: rtl/pio_cycle_counter.sv
module pio_cycle_counter
  import pio_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic hold,
  input  cnt_t last_at,
  output logic busy_q,
  output cnt_t cnt_q,
  output logic last
);

  logic busy_d;
  cnt_t cnt_d;

  assign last = busy_q && (cnt_q == last_at);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q && !hold) begin
      cnt_d = cnt_q + cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2: an accepted start begins a cycle at count 0
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && cnt_q == '0));

  // R4: the terminal count ends the cycle unless a start chains
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !accept) |=> !busy_q);

  // R7: a stall freezes the counter
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hold) |=> (busy_q && cnt_q == $past(cnt_q)));

endmodule

// File: rtl/pio_strobe_decode.sv
module pio_strobe_decode
  import pio_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              busy,
  input  cnt_t              cnt,
  input  cnt_t              on_at,
  input  cnt_t              off_at,
  input  logic              last,
  input  logic              write_q,
  input  logic [DATA_W-1:0] data_q,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              done
);

  logic in_window;

  assign in_window = busy && (cnt >= on_at) && (cnt <= off_at);

  always_comb begin
    rd_strobe = in_window && !write_q;
    wr_strobe = in_window &&  write_q;
    bus_oe    = busy && write_q;
    bus_data  = bus_oe ? data_q : '0;
    done      = last;
  end

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int MAX_WAIT_NS   = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [2:0]        mode_i,
  input  logic              iordy_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_strobe_o,
  output logic              wr_strobe_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam int STALL_LIMIT = MAX_WAIT_NS / CLK_PERIOD_NS;

  logic              rst_sync_n;
  logic              busy;
  logic              last;
  logic              accept;
  logic              hold;
  cnt_t              cnt;
  mode_t             mode_q;
  logic              write_q;
  logic [DATA_W-1:0] data_q;
  edge_set_t         edges;

  pio_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // Start is taken when idle or in the done cycle (chaining).
  assign accept = start_i && (!busy || last);
  assign edges  = lookup_edges(mode_q);

  pio_req_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .accept  (accept),
    .busy    (busy),
    .last    (last),
    .mode_i  (mode_i),
    .write_i (write_i),
    .wdata_i (wdata_i),
    .mode_q  (mode_q),
    .write_q (write_q),
    .data_q  (data_q)
  );

  pio_stall_guard #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .busy      (busy),
    .cnt       (cnt),
    .off_at    (edges.off_at),
    .iordy_i   (iordy_i),
    .hold      (hold),
    .timeout_q (timeout_o)
  );

  pio_cycle_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .accept  (accept),
    .hold    (hold),
    .last_at (edges.last_at),
    .busy_q  (busy),
    .cnt_q   (cnt),
    .last    (last)
  );

  pio_strobe_decode #(.DATA_W(DATA_W)) u_decode (
    .busy      (busy),
    .cnt       (cnt),
    .on_at     (edges.on_at),
    .off_at    (edges.off_at),
    .last      (last),
    .write_q   (write_q),
    .data_q    (data_q),
    .rd_strobe (rd_strobe_o),
    .wr_strobe (wr_strobe_o),
    .bus_oe    (bus_oe_o),
    .bus_data  (bus_data_o),
    .done      (done_o)
  );

  // R3: read and write strobes are exclusive
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rd_strobe_o && wr_strobe_o));

  // R5: a write strobe is always backed by the bus output enable
  a_r5_oe_with_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_strobe_o |-> bus_oe_o);

  // R10: done is a single-clock pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R6: a start in mid-cycle does not restart the count
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !last) |=> busy);

endmodule

// File: tb/pio_cycle_timer_bench.sv
module pio_cycle_timer_bench;

  localparam int DW    = 16;
  localparam int LIMIT = 125;

  typedef struct packed {
    logic [2:0]  mode;
    logic        wr;
    logic [15:0] data;
    int          stall;
    int          on_at;
    int          off_at;
    int          last_at;
    logic        chain;
  } vec_t;

  // mode, write, data, stall, on, off, last, chain-next
  localparam vec_t VECS [0:13] = '{
    '{3'd0, 1'b0, 16'h0000,    0, 7, 36, 67, 1'b0},
    '{3'd0, 1'b1, 16'hA5A5,    0, 7, 36, 67, 1'b0},
    '{3'd1, 1'b0, 16'h0000,    0, 5, 34, 45, 1'b0},
    '{3'd1, 1'b1, 16'h1234,    3, 5, 34, 45, 1'b0},
    '{3'd2, 1'b1, 16'hBEEF,    0, 3, 33, 37, 1'b0},
    '{3'd2, 1'b0, 16'h0000,   10, 3, 33, 37, 1'b0},
    '{3'd3, 1'b1, 16'h0F0F,    0, 3, 11, 22, 1'b1},
    '{3'd3, 1'b0, 16'h0000,    0, 3, 11, 22, 1'b0},
    '{3'd4, 1'b1, 16'hFFFF,    0, 3, 10, 16, 1'b0},
    '{3'd4, 1'b0, 16'h0000,    1, 3, 10, 16, 1'b0},
    '{3'd6, 1'b1, 16'h8001,    0, 3, 10, 16, 1'b0},
    '{3'd4, 1'b1, 16'h5555,  125, 3, 10, 16, 1'b0},
    '{3'd3, 1'b0, 16'h0000,  126, 3, 11, 22, 1'b0},
    '{3'd0, 1'b1, 16'h7E7E, 1000, 7, 36, 67, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          write_i;
  logic [2:0]    mode_i;
  logic          iordy_i;
  logic [DW-1:0] wdata_i;
  logic          rd_strobe_o;
  logic          wr_strobe_o;
  logic          bus_oe_o;
  logic [DW-1:0] bus_data_o;
  logic          done_o;
  logic          timeout_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pio_cycle_timer #(.DATA_W(DW)) u_pio_cycle_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .write_i     (write_i),
    .mode_i      (mode_i),
    .iordy_i     (iordy_i),
    .wdata_i     (wdata_i),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .bus_oe_o    (bus_oe_o),
    .bus_data_o  (bus_data_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " rd strobe"}, int'(rd_strobe_o), 0);
    chk({tag, " wr strobe"}, int'(wr_strobe_o), 0);
    chk({tag, " oe"},        int'(bus_oe_o), 0);
    chk({tag, " data"},      int'(bus_data_o), 0);
    chk({tag, " done"},      int'(done_o), 0);
    chk({tag, " timeout"},   int'(timeout_o), 0);
  endtask

  // Caller is at a negedge; start is taken at the next posedge.
  task automatic run_vec(input vec_t v, input int idx);
    int eff   = (v.stall > LIMIT) ? LIMIT : v.stall;
    int exp_to = (v.stall > LIMIT) ? 1 : 0;
    int first = -1;
    int lastk = -1;
    int donek = -1;
    int bad_stb = 0;
    int bad_oe = 0;
    int bad_data = 0;
    int to_at_done = 0;
    logic own, other;
    mode_i  = v.mode;
    write_i = v.wr;
    wdata_i = v.data;
    iordy_i = (v.stall == 0);
    start_i = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start_i = 1'b0;
        chk($sformatf("R8 vec%0d timeout cleared at start", idx), int'(timeout_o), 0);
      end
      own   = v.wr ? wr_strobe_o : rd_strobe_o;
      other = v.wr ? rd_strobe_o : wr_strobe_o;
      if (own) begin
        if (first < 0) first = k;
        lastk = k;
      end
      if (other) bad_stb++;
      if (bus_oe_o != v.wr) bad_oe++;
      if (bus_data_o != (v.wr ? v.data : 16'h0000)) bad_data++;
      if (done_o) begin
        donek = k;
        to_at_done = int'(timeout_o);
        break;
      end
      if (k == 5) begin
        mode_i  = v.mode ^ 3'd3;
        write_i = ~v.wr;
        wdata_i = ~v.data;
        start_i = 1'b1;
      end
      if (k == 6) start_i = 1'b0;
      if (k == v.off_at + v.stall) iordy_i = 1'b1;
    end
    iordy_i = 1'b1;
    chk($sformatf("R2,R4 vec%0d strobe first count", idx), first, v.on_at);
    chk($sformatf("R4,R7 vec%0d strobe last count", idx), lastk, v.off_at + eff);
    chk($sformatf("R10 vec%0d done count", idx), donek, v.last_at + eff);
    chk($sformatf("R3 vec%0d wrong strobe cycles", idx), bad_stb, 0);
    chk($sformatf("R5 vec%0d oe mismatch cycles", idx), bad_oe, 0);
    chk($sformatf("R5,R9 vec%0d data mismatch cycles", idx), bad_data, 0);
    chk($sformatf("R8 vec%0d timeout at done", idx), to_at_done, exp_to);
    if (!v.chain) begin
      @(negedge clk);
      // R6: mid-cycle start must not have queued a new transfer
      chk($sformatf("R6 vec%0d idle after done strobe", idx),
          int'(rd_strobe_o | wr_strobe_o), 0);
      chk($sformatf("R10 vec%0d done one clock", idx), int'(done_o), 0);
      chk($sformatf("R6 vec%0d idle oe", idx), int'(bus_oe_o), 0);
      chk($sformatf("R8 vec%0d timeout held after done", idx), int'(timeout_o), exp_to);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got no completion expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    write_i = 1'b0;
    mode_i  = 3'd0;
    iordy_i = 1'b1;
    wdata_i = '0;
    repeat (3) @(negedge clk);
    chk_quiet("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_quiet("R1 after release");

    for (int i = 0; i < 14; i++) begin
      run_vec(VECS[i], i);
    end

    // R1: reset in the middle of a write transfer clears all outputs
    mode_i  = 3'd0;
    write_i = 1'b1;
    wdata_i = 16'hC3C3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 oe mid write before reset", int'(bus_oe_o), 1);
    chk("R3 wr strobe mid write before reset", int'(wr_strobe_o), 1);
    rst_n = 1'b0;
    #1;
    chk_quiet("R1 mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_quiet("R1 after mid-cycle reset");

    // Recovery: a plain mode 4 read after reset
    run_vec('{3'd4, 1'b0, 16'h0000, 0, 3, 10, 16, 1'b0}, 99);

    report();
    $finish;
  end

endmodule